// File: doc/BRIEF.md
# Command-Sequence Write Protection Sequencer

This block sits in front of the page-write path of a byte-wide nonvolatile memory. It watches every accepted write strobe (address and data). It recognises two fixed command patterns: a three-byte unlock sequence and a six-byte disable sequence. From these it keeps a protection flag that survives power cycles. The write controller owns the page buffer and the timers. It tells this block when the byte-load window has timed out (`win_timeout`) and when the programming period has ended (`prog_done`).

For each accepted byte, the block decides whether the byte goes to the page buffer or is held back as a command byte. When a load window closes, it starts the programming cycle and tells the write controller whether the buffered data may really be committed. If protection is on and the window held no unlock sequence, the cycle still runs but stores nothing. An unlock sequence authorises the data of its own window. It also arms protection, which takes effect when that programming period ends. The disable sequence authorises its window as well, and clears protection when that period ends.

The `rst` input models a power transition: it clears the matcher and the window logic, but it leaves the protection flag alone. Only `factory_rst` clears the flag.

Top module: `swp_sequencer`

## Requirements
- R1: After `factory_rst` with `rst`, `prot_on` is 0, and `buf_we` and `start_prog` are 0.
- R2: Asserting `rst` alone leaves `prot_on` unchanged. It also clears any partly matched command sequence, so a byte A0h to address 1555h sent after `rst` reaches the buffer as data.
- R3: An accepted byte that is not a command step appears on `buf_we`, `buf_addr` and `buf_data` on the next cycle. A byte that matches the next expected command step raises no `buf_we`.
- R4: `win_timeout` while at least one byte was accepted since the last window close makes `start_prog` pulse for one cycle on the next cycle. `win_timeout` with no accepted byte has no effect.
- R5: With protection off, every programming cycle has `commit` = 1.
- R6: With protection on, a window without a completed command sequence gives `start_prog` with `commit` = 0.
- R7: With protection on, a window holding the unlock sequence gives `commit` = 1. The unlock sequence is AAh to 1555h, then 55h to 0AAAh, then A0h to 1555h, with 13-bit addresses.
- R8: The unlock sequence sets `prot_on` on the cycle after the `prog_done` that ends that window's programming period. This holds even when the window carried no data. `prot_on` does not change before that `prog_done`.
- R9: The disable sequence is AAh to 1555h, 55h to 0AAAh, 80h to 1555h, AAh to 1555h, 55h to 0AAAh, then 20h to 1555h. It gives `commit` = 1 and clears `prot_on` on the cycle after the following `prog_done`.
- R10: A byte that breaks a partial sequence returns the matcher to its first step. That byte goes to the buffer as data, and later bytes of the broken sequence count as data too.
- R11: A load-window timeout between command bytes breaks the sequence. A final step sent in the next window is plain data.
- R12: Write strobes between `start_prog` and `prog_done` are ignored.
- R13: `factory_rst` clears `prot_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-cycle reset; keeps the protection flag |
| factory_rst | input | 1 | Synchronous reset that also clears the protection flag |
| wr_stb | input | 1 | One accepted write byte this cycle |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| win_timeout | input | 1 | Byte-load timer expired; closes the load window |
| prog_done | input | 1 | Programming period finished |
| buf_we | output | 1 | Store a data byte into the page buffer |
| buf_addr | output | 13 | Address for the page buffer |
| buf_data | output | 8 | Data for the page buffer |
| start_prog | output | 1 | One-cycle pulse that starts the programming timer |
| commit | output | 1 | Valid with `start_prog`: 1 stores the buffer, 0 runs a dummy cycle |
| prot_on | output | 1 | Current protection state |

## Verification
The bench targets four corner cases:
- **Protection timing.** Protection must switch only after the programming period of the enabling window. A design that switched it at the window close would block the data loaded behind the unlock in a later window.
- **Broken sequences.** These are checked both by a wrong address at the third step and by a load timeout between steps. A matcher that kept partial progress would turn a stray A0h byte into an unlock, or would silently drop user bytes.
- **Command-only windows and strobes during busy.** A window holding only command bytes must still start a cycle. Strobes that arrive while busy must be dropped.
- **Power-cycle reset.** The bench checks that the flag survives `rst` while the matcher does not.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int STEPS  = 6;
    localparam int STEP_W = $clog2(STEPS);
    localparam int UNLOCK_STEP = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } wbyte_t;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } act_e;

    localparam addr_t CMD_ADDR_HI = 13'h1555;
    localparam addr_t CMD_ADDR_LO = 13'h0AAA;
    localparam data_t KEY_FIRST   = 8'hAA;
    localparam data_t KEY_SECOND  = 8'h55;
    localparam data_t KEY_UNLOCK  = 8'hA0;
    localparam data_t KEY_ERASE   = 8'h80;
    localparam data_t KEY_DISABLE = 8'h20;

    // Expected byte for each step of the long (disable) pattern; the
    // short pattern shares steps 0 and 1 and branches at UNLOCK_STEP.
    function automatic wbyte_t step_cmd(input step_t s);
        wbyte_t w;
        case (s)
            step_t'(0), step_t'(3): w = '{addr: CMD_ADDR_HI, data: KEY_FIRST};
            step_t'(1), step_t'(4): w = '{addr: CMD_ADDR_LO, data: KEY_SECOND};
            step_t'(2):             w = '{addr: CMD_ADDR_HI, data: KEY_ERASE};
            default:                w = '{addr: CMD_ADDR_HI, data: KEY_DISABLE};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/swp_cmd_matcher.sv
module swp_cmd_matcher
    import swp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   stb,
    input  wbyte_t wb,
    output logic   is_cmd,
    output logic   unlock_hit,
    output logic   disable_hit
);

    step_t  step_q;
    step_t  step_d;
    wbyte_t expect_b;

    always_comb begin
        expect_b    = step_cmd(step_q);
        is_cmd      = 1'b0;
        unlock_hit  = 1'b0;
        disable_hit = 1'b0;
        step_d      = step_q;
        if (stb) begin
            if (step_q == step_t'(UNLOCK_STEP) && wb.addr == CMD_ADDR_HI &&
                wb.data == KEY_UNLOCK) begin
                is_cmd     = 1'b1;
                unlock_hit = 1'b1;
                step_d     = '0;
            end else if (wb == expect_b) begin
                is_cmd = 1'b1;
                if (step_q == step_t'(STEPS-1)) begin
                    disable_hit = 1'b1;
                    step_d      = '0;
                end else begin
                    step_d = step_q + step_t'(1);
                end
            end else begin
                step_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) step_q <= '0;
        else              step_q <= step_d;
    end

endmodule

// File: rtl/swp_window_ctrl.sv
module swp_window_ctrl
    import swp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic close,
    input  logic prog_done,
    input  logic prot,
    input  logic unlock_hit,
    input  logic disable_hit,
    output logic start_prog,
    output logic commit,
    output logic busy,
    output logic apply_set,
    output logic apply_clr
);

    logic open_q;
    logic busy_q;
    logic start_q;
    logic commit_q;
    act_e act_q;
    act_e pend_q;
    logic close_ok;
    logic finish;

    assign close_ok = close && open_q;
    assign finish   = prog_done && busy_q && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            busy_q   <= 1'b0;
            start_q  <= 1'b0;
            commit_q <= 1'b0;
            act_q    <= ACT_NONE;
            pend_q   <= ACT_NONE;
        end else begin
            start_q <= close_ok;
            if (close_ok) begin
                open_q   <= 1'b0;
                busy_q   <= 1'b1;
                commit_q <= !prot || (act_q != ACT_NONE);
                pend_q   <= act_q;
                act_q    <= ACT_NONE;
            end else if (stb) begin
                open_q <= 1'b1;
                if (unlock_hit)       act_q <= ACT_SET;
                else if (disable_hit) act_q <= ACT_CLR;
            end
            if (finish) begin
                busy_q <= 1'b0;
                pend_q <= ACT_NONE;
            end
        end
    end

    assign start_prog = start_q;
    assign commit     = commit_q;
    assign busy       = busy_q;
    assign apply_set  = finish && (pend_q == ACT_SET);
    assign apply_clr  = finish && (pend_q == ACT_CLR);

endmodule

// File: rtl/swp_nv_flag.sv
module swp_nv_flag (
    input  logic clk,
    input  logic factory_rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (factory_rst) flag_q <= 1'b0;
        else if (set)    flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
    import swp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              factory_rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_timeout,
    input  logic              prog_done,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_data,
    output logic              start_prog,
    output logic              commit,
    output logic              prot_on
);

    logic   busy;
    logic   accept;
    logic   is_cmd;
    logic   unlock_hit;
    logic   disable_hit;
    logic   apply_set;
    logic   apply_clr;
    logic   cur_rst;
    wbyte_t wb;

    logic  buf_we_q;
    addr_t buf_addr_q;
    data_t buf_data_q;

    assign cur_rst = rst || factory_rst;
    assign accept  = wr_stb && !busy && !win_timeout;
    assign wb      = '{addr: wr_addr, data: wr_data};

    swp_cmd_matcher u_match (
        .clk        (clk),
        .rst        (cur_rst),
        .clear      (win_timeout),
        .stb        (accept),
        .wb         (wb),
        .is_cmd     (is_cmd),
        .unlock_hit (unlock_hit),
        .disable_hit(disable_hit)
    );

    swp_window_ctrl u_win (
        .clk        (clk),
        .rst        (cur_rst),
        .stb        (accept),
        .close      (win_timeout),
        .prog_done  (prog_done),
        .prot       (prot_on),
        .unlock_hit (unlock_hit),
        .disable_hit(disable_hit),
        .start_prog (start_prog),
        .commit     (commit),
        .busy       (busy),
        .apply_set  (apply_set),
        .apply_clr  (apply_clr)
    );

    swp_nv_flag u_nv (
        .clk        (clk),
        .factory_rst(factory_rst),
        .set        (apply_set),
        .clr        (apply_clr),
        .flag       (prot_on)
    );

    always_ff @(posedge clk) begin
        if (cur_rst) buf_we_q <= 1'b0;
        else         buf_we_q <= accept && !is_cmd;
        if (accept) begin
            buf_addr_q <= wr_addr;
            buf_data_q <= wr_data;
        end
    end

    assign buf_we   = buf_we_q;
    assign buf_addr = buf_addr_q;
    assign buf_data = buf_data_q;

endmodule

// File: rtl/swp_sequencer_chk.sv
module swp_sequencer_chk
    import swp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              factory_rst,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              win_timeout,
    input logic              prog_done,
    input logic              busy,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              start_prog,
    input logic              commit,
    input logic              prot_on
);

    // R3
    buf_pass_chk: assert property (@(posedge clk) disable iff (rst || factory_rst)
        buf_we |-> ($past(wr_stb) && buf_addr == $past(wr_addr)));

    // R12
    busy_block_chk: assert property (@(posedge clk) disable iff (rst || factory_rst)
        buf_we |-> !$past(busy));

    // R4
    start_src_chk: assert property (@(posedge clk) disable iff (rst || factory_rst)
        start_prog |-> $past(win_timeout));

    // R6
    dummy_cycle_chk: assert property (@(posedge clk) disable iff (rst || factory_rst)
        (start_prog && !commit) |-> prot_on);

    // R8
    prot_change_chk: assert property (@(posedge clk) disable iff (rst || factory_rst)
        !$stable(prot_on) |-> $past(prog_done));

    // R2
    power_keep_chk: assert property (@(posedge clk) disable iff (factory_rst)
        $past(rst) |-> prot_on == $past(prot_on));

endmodule

bind swp_sequencer swp_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .factory_rst(factory_rst),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .win_timeout(win_timeout),
    .prog_done  (prog_done),
    .busy       (busy),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .start_prog (start_prog),
    .commit     (commit),
    .prot_on    (prot_on)
);

// File: tb/swp_sequencer_bench.sv
module swp_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 47;

    localparam logic [1:0] OP_WR = 2'd1;
    localparam logic [1:0] OP_TO = 2'd2;
    localparam logic [1:0] OP_PD = 2'd3;

    // Row: op, addr, data, expected buf_we, start_prog, commit, prot_on
    function automatic logic [26:0] mk(input logic [1:0] op, input logic [12:0] a,
                                       input logic [7:0] d, input logic we,
                                       input logic sp, input logic cm, input logic pr);
        return {op, a, d, we, sp, cm, pr};
    endfunction

    localparam logic [26:0] VEC [NROWS] = '{
        // R3 R5: plain writes while unprotected, window close commits
        mk(OP_WR, 13'h0010, 8'h11, 1, 0, 0, 0),
        mk(OP_WR, 13'h0011, 8'h22, 1, 0, 0, 0),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 1, 0),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 0),
        // R4: timeout on an empty window does nothing
        mk(OP_TO, 13'h0000, 8'h00, 0, 0, 0, 0),
        // R8: enable plus data, protection only after prog_done
        mk(OP_WR, 13'h1555, 8'hAA, 0, 0, 0, 0),
        mk(OP_WR, 13'h0AAA, 8'h55, 0, 0, 0, 0),
        mk(OP_WR, 13'h1555, 8'hA0, 0, 0, 0, 0),
        mk(OP_WR, 13'h0040, 8'h33, 1, 0, 0, 0),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 1, 0),
        // R12: strobe while busy is dropped
        mk(OP_WR, 13'h0050, 8'h44, 0, 0, 0, 0),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 1),
        // R6: protected write without unlock is a dummy cycle
        mk(OP_WR, 13'h0060, 8'h55, 1, 0, 0, 1),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 0, 1),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 1),
        // R7: unlock authorises the window
        mk(OP_WR, 13'h1555, 8'hAA, 0, 0, 0, 1),
        mk(OP_WR, 13'h0AAA, 8'h55, 0, 0, 0, 1),
        mk(OP_WR, 13'h1555, 8'hA0, 0, 0, 0, 1),
        mk(OP_WR, 13'h0070, 8'h66, 1, 0, 0, 1),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 1, 1),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 1),
        // R10: wrong third step breaks the match
        mk(OP_WR, 13'h1555, 8'hAA, 0, 0, 0, 1),
        mk(OP_WR, 13'h0AAA, 8'h55, 0, 0, 0, 1),
        mk(OP_WR, 13'h0AAA, 8'h55, 1, 0, 0, 1),
        mk(OP_WR, 13'h1555, 8'hA0, 1, 0, 0, 1),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 0, 1),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 1),
        // R11: timeout between steps breaks the match
        mk(OP_WR, 13'h1555, 8'hAA, 0, 0, 0, 1),
        mk(OP_WR, 13'h0AAA, 8'h55, 0, 0, 0, 1),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 0, 1),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 1),
        mk(OP_WR, 13'h1555, 8'hA0, 1, 0, 0, 1),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 0, 1),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 1),
        // R9: six-byte disable
        mk(OP_WR, 13'h1555, 8'hAA, 0, 0, 0, 1),
        mk(OP_WR, 13'h0AAA, 8'h55, 0, 0, 0, 1),
        mk(OP_WR, 13'h1555, 8'h80, 0, 0, 0, 1),
        mk(OP_WR, 13'h1555, 8'hAA, 0, 0, 0, 1),
        mk(OP_WR, 13'h0AAA, 8'h55, 0, 0, 0, 1),
        mk(OP_WR, 13'h1555, 8'h20, 0, 0, 0, 1),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 1, 1),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 0),
        // R8: command-only enable window
        mk(OP_WR, 13'h1555, 8'hAA, 0, 0, 0, 0),
        mk(OP_WR, 13'h0AAA, 8'h55, 0, 0, 0, 0),
        mk(OP_WR, 13'h1555, 8'hA0, 0, 0, 0, 0),
        mk(OP_TO, 13'h0000, 8'h00, 0, 1, 1, 0),
        mk(OP_PD, 13'h0000, 8'h00, 0, 0, 0, 1)
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        factory_rst;
    logic        wr_stb;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        win_timeout;
    logic        prog_done;
    logic        buf_we;
    logic [12:0] buf_addr;
    logic [7:0]  buf_data;
    logic        start_prog;
    logic        commit;
    logic        prot_on;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swp_sequencer u_swp_sequencer (
        .clk        (clk),
        .rst        (rst),
        .factory_rst(factory_rst),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .win_timeout(win_timeout),
        .prog_done  (prog_done),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_data   (buf_data),
        .start_prog (start_prog),
        .commit     (commit),
        .prot_on    (prot_on)
    );

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [12:0] a, input logic [7:0] d);
        wr_stb      = (op == OP_WR);
        wr_addr     = a;
        wr_data     = d;
        win_timeout = (op == OP_TO);
        prog_done   = (op == OP_PD);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        factory_rst = 1'b1;
        drive(2'd0, '0, '0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        factory_rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(prot_on == 1'b0, "R1 prot_on", prot_on, 0);
        chk(buf_we == 1'b0, "R1 buf_we", buf_we, 0);
        chk(start_prog == 1'b0, "R1 start_prog", start_prog, 0);

        for (int i = 0; i < NROWS; i++) begin
            logic [26:0] v;
            v = VEC[i];
            drive(v[26:25], v[24:12], v[11:4]);
            @(negedge clk);
            chk(buf_we == v[3], $sformatf("R3 row %0d buf_we", i), buf_we, v[3]);
            if (v[3]) begin
                chk(buf_addr == v[24:12] && buf_data == v[11:4],
                    $sformatf("R3 row %0d buf addr/data", i),
                    {buf_addr, buf_data}, v[24:4]);
            end
            chk(start_prog == v[2], $sformatf("R4 row %0d start_prog", i), start_prog, v[2]);
            if (v[2]) begin
                chk(commit == v[1], $sformatf("R5 R6 R7 row %0d commit", i), commit, v[1]);
            end
            chk(prot_on == v[0], $sformatf("R8 R9 row %0d prot_on", i), prot_on, v[0]);
        end
        drive(2'd0, '0, '0);
        @(negedge clk);

        // R2: power-cycle reset keeps protection, clears partial match
        drive(OP_WR, 13'h1555, 8'hAA);
        @(negedge clk);
        drive(OP_WR, 13'h0AAA, 8'h55);
        @(negedge clk);
        drive(2'd0, '0, '0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(prot_on == 1'b1, "R2 prot_on after rst", prot_on, 1);
        drive(OP_WR, 13'h1555, 8'hA0);
        @(negedge clk);
        chk(buf_we == 1'b1, "R2 stray step after rst is data", buf_we, 1);
        drive(OP_TO, '0, '0);
        @(negedge clk);
        chk(start_prog && !commit, "R2 R6 dummy cycle after rst", {start_prog, commit}, 2'b10);
        drive(OP_PD, '0, '0);
        @(negedge clk);
        chk(prot_on == 1'b1, "R2 prot_on kept", prot_on, 1);
        drive(2'd0, '0, '0);

        // R13: factory reset clears protection
        factory_rst = 1'b1;
        repeat (2) @(negedge clk);
        factory_rst = 1'b0;
        chk(prot_on == 1'b0, "R13 prot_on cleared", prot_on, 0);
        drive(OP_WR, 13'h0123, 8'h5A);
        @(negedge clk);
        drive(OP_TO, '0, '0);
        @(negedge clk);
        chk(start_prog && commit, "R13 R5 commit after factory reset", {start_prog, commit}, 2'b11);
        drive(OP_PD, '0, '0);
        @(negedge clk);
        drive(2'd0, '0, '0);
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule